// File: doc/BRIEF.md
# Dual-Output Sawtooth PWM Timer Channel

This block is one timer channel built around an up-counter that climbs from zero to a programmed period and then drops back to zero. Each climb is one PWM cycle. A prescaler divides the core clock by a power of four and sets the rate at which the counter steps. Two pin outputs, A and B, share that counter and that period. Each pin has its own compare word, its own action code and its own enable. A pin is high from the start of each cycle and flips when the counter steps onto its compare value. For a counter that starts from zero, the pin is therefore high while the count is below the compare value and low for the rest of the cycle.

Software drives the block through a plain 32-bit register port. A write strobe writes the word at `reg_addr` on the rising clock edge. Read data is a combinational function of `reg_addr`. The port has no data stream and no handshake. Software normally stops the channel, sets the mode and prescale, loads the counter with zero and then sets the start bit. The mode and prescale fields are locked while the channel runs. The period, compare and counter words can be rewritten at any time.

Top module: `pwm_saw_timer`

## Requirements
- R1: A synchronous active-low reset clears every register to zero. After reset every mapped offset reads 0 and both pins are low.
- R2: The register map is as follows.
  - 0x2C control: run bit 0, mode bits 18:16, prescale code bits 26:24.
  - 0x30 direction: bits 1:0.
  - 0x34 pin control: A action bits 4:0, A enable bit 8, B action bits 20:16, B enable bit 24.
  - 0x40 buffer enable: 32 bits.
  - 0x48 counter.
  - 0x4C compare A.
  - 0x50 compare B.
  - 0x64 period.
  - Unmapped bits and unmapped offsets read 0.
- R3: While the run bit is 1, writes to control change only the run bit. The mode and prescale fields keep their values, even when the same write clears the run bit.
- R4: The counter steps up by one on each prescaler tick only while run=1 and mode=0 (sawtooth). In every other state it holds its value. Reading offset 0x48 returns the live count.
- R5: On a tick where the counter is greater than or equal to the period, the counter goes to 0. A cycle therefore lasts period+1 ticks.
- R6: Prescale code n gives one tick every 4^n clocks. Codes 6 and 7 behave as code 5, which divides by 1024. The first tick after counting starts comes 4^n clocks after the start.
- R7: A write to the counter takes effect on that same edge and wins over a tick on that edge.
- R8: Each pin level is set high when counting starts and at every wrap. On the wrap tick the level instead goes low when the compare value is 0. The level also toggles on every tick that moves the counter onto the pin's compare value.
- R9: A compare value greater than the period never matches, so that pin stays high for the whole cycle.
- R10: A pin is driven high only when all of these hold: run=1, mode=0, its enable bit is 1, its action code is 0x1B and its level is high. In every other state the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_a | output | 1 | PWM output A |
| pin_b | output | 1 | PWM output B |

## Verification
The hardest cases to reach are the slow prescale settings. At the top code the counter steps only once every 1024 clocks, and the invalid codes 6 and 7 must alias to that same rate. The stimulus first stops the channel, which is the only state in which the prescale field can be written. It then zeroes the counter and starts the channel with the code under test. It reads the live counter exactly one clock before and one clock after each expected tick, so a divider that is off by one clock shows up. The lock on the mode and prescale fields during counting is reached in a similar way: a write that clears the run bit still has to leave the locked fields untouched.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int DATA_W = 32;
  localparam int PSC_W  = 3;
  localparam int MODE_W = 3;
  localparam int ACT_W  = 5;

  localparam logic [7:0] OFS_CTRL = 8'h2C;
  localparam logic [7:0] OFS_DIR  = 8'h30;
  localparam logic [7:0] OFS_PINC = 8'h34;
  localparam logic [7:0] OFS_BUFE = 8'h40;
  localparam logic [7:0] OFS_CNT  = 8'h48;
  localparam logic [7:0] OFS_CMPA = 8'h4C;
  localparam logic [7:0] OFS_CMPB = 8'h50;
  localparam logic [7:0] OFS_PER  = 8'h64;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_MODE_LSB = 16;
  localparam int CTRL_PSC_LSB  = 24;

  localparam int PINC_ACT_LSB_A = 0;
  localparam int PINC_EN_BIT_A  = 8;
  localparam int PINC_ACT_LSB_B = 16;
  localparam int PINC_EN_BIT_B  = 24;

  localparam logic [MODE_W-1:0] MODE_SAW    = '0;
  localparam logic [ACT_W-1:0]  ACT_HI_TOGL = 5'h1B;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W   = 3,
  parameter int PSC_MAX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = 2 * PSC_MAX;

  logic [PSC_W-1:0] eff_code;
  logic [DIV_W:0]   span_m1;
  logic [DIV_W-1:0] pcnt_q;

  always_comb begin
    eff_code = (code > PSC_W'(PSC_MAX)) ? PSC_W'(PSC_MAX) : code;
    span_m1  = ((DIV_W+1)'(1) << (2 * eff_code)) - (DIV_W+1)'(1);
  end

  assign tick = run && (pcnt_q == span_m1[DIV_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)     pcnt_q <= '0;
    else if (!run)  pcnt_q <= '0;
    else if (tick)  pcnt_q <= '0;
    else            pcnt_q <= pcnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_code != '0) |=> !tick); // R6
endmodule

// File: rtl/pwm_saw_counter.sv
module pwm_saw_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && (cnt >= period);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_en)  cnt <= wr_val;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt >= period && !wr_en) |=> (cnt == '0)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt < period && !wr_en) |=> (cnt == $past(cnt) + 1'b1)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt)); // R4
endmodule

// File: rtl/pwm_pin_gen.sv
module pwm_pin_gen
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             en,
  input  logic [ACT_W-1:0] act,
  output logic             pin
);
  logic lvl_q;
  logic step_hit;

  assign step_hit = (CNT_W'(cnt + 1'b1) == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n)          lvl_q <= 1'b0;
    else if (!run)       lvl_q <= 1'b1;
    else if (wrap)       lvl_q <= (cmp != '0);
    else if (tick && step_hit) lvl_q <= ~lvl_q;
  end

  assign pin = run && en && (act == ACT_HI_TOGL) && lvl_q;

  AST_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap && cmp != '0) |=> (lvl_q || !run)); // R8
endmodule

// File: rtl/pwm_saw_timer.sv
module pwm_saw_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PSC_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pin_a,
  output logic              pin_b
);
  localparam int NPIN = 2;
  localparam int ACT_LSB [NPIN] = '{PINC_ACT_LSB_A, PINC_ACT_LSB_B};
  localparam int EN_BIT  [NPIN] = '{PINC_EN_BIT_A, PINC_EN_BIT_B};

  logic              start_q;
  logic [MODE_W-1:0] mode_q;
  logic [PSC_W-1:0]  psc_q;
  logic [1:0]        dir_q;
  logic [DATA_W-1:0] bufe_q;
  logic [CNT_W-1:0]  per_q;
  logic [CNT_W-1:0]  cmp_q  [NPIN];
  logic [ACT_W-1:0]  act_q  [NPIN];
  logic              en_q   [NPIN];

  logic             run;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic             cnt_wr;
  logic [NPIN-1:0]  pins;

  assign run    = start_q && (mode_q == MODE_SAW);
  assign cnt_wr = reg_wr && (reg_addr == OFS_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      mode_q  <= '0;
      psc_q   <= '0;
      dir_q   <= '0;
      bufe_q  <= '0;
      per_q   <= '0;
      for (int i = 0; i < NPIN; i++) begin
        cmp_q[i] <= '0;
        act_q[i] <= '0;
        en_q[i]  <= 1'b0;
      end
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CTRL: begin
          start_q <= reg_wdata[CTRL_RUN_BIT];
          if (!start_q) begin
            mode_q <= reg_wdata[CTRL_MODE_LSB +: MODE_W];
            psc_q  <= reg_wdata[CTRL_PSC_LSB +: PSC_W];
          end
        end
        OFS_DIR:  dir_q  <= reg_wdata[1:0];
        OFS_BUFE: bufe_q <= reg_wdata;
        OFS_PER:  per_q  <= reg_wdata[CNT_W-1:0];
        OFS_CMPA: cmp_q[0] <= reg_wdata[CNT_W-1:0];
        OFS_CMPB: cmp_q[1] <= reg_wdata[CNT_W-1:0];
        OFS_PINC: begin
          for (int i = 0; i < NPIN; i++) begin
            act_q[i] <= reg_wdata[ACT_LSB[i] +: ACT_W];
            en_q[i]  <= reg_wdata[EN_BIT[i]];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CTRL_RUN_BIT]           = start_q;
        reg_rdata[CTRL_MODE_LSB +: MODE_W] = mode_q;
        reg_rdata[CTRL_PSC_LSB +: PSC_W]   = psc_q;
      end
      OFS_DIR:  reg_rdata[1:0] = dir_q;
      OFS_BUFE: reg_rdata = bufe_q;
      OFS_CNT:  reg_rdata[CNT_W-1:0] = cnt;
      OFS_CMPA: reg_rdata[CNT_W-1:0] = cmp_q[0];
      OFS_CMPB: reg_rdata[CNT_W-1:0] = cmp_q[1];
      OFS_PER:  reg_rdata[CNT_W-1:0] = per_q;
      OFS_PINC: begin
        for (int i = 0; i < NPIN; i++) begin
          reg_rdata[ACT_LSB[i] +: ACT_W] = act_q[i];
          reg_rdata[EN_BIT[i]]           = en_q[i];
        end
      end
      default: reg_rdata = '0;
    endcase
  end

  pwm_prescaler #(.PSC_W(PSC_W), .PSC_MAX(PSC_MAX)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .code(psc_q), .tick(tick)
  );

  pwm_saw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(cnt_wr),
    .wr_val(reg_wdata[CNT_W-1:0]), .period(per_q), .cnt(cnt), .wrap(wrap)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    pwm_pin_gen #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .wrap(wrap),
      .cnt(cnt), .cmp(cmp_q[g]), .en(en_q[g]), .act(act_q[g]), .pin(pins[g])
    );
  end

  assign pin_a = pins[0];
  assign pin_b = pins[1];

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> ($stable(mode_q) && $stable(psc_q))); // R3
  AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |-> (!pin_a && !pin_b)); // R10
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R4
endmodule

// File: tb/pwm_saw_timer_tb.sv
module pwm_saw_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pin_a, pin_b;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [7:0] A_CTRL = 8'h2C, A_DIR = 8'h30, A_PINC = 8'h34,
    A_BUFE = 8'h40, A_CNT = 8'h48, A_CMPA = 8'h4C, A_CMPB = 8'h50, A_PER = 8'h64;

  always #4 clk = ~clk;

  pwm_saw_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_a(pin_a), .pin_b(pin_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [7:0] offs [8] = '{A_CTRL, A_DIR, A_PINC, A_BUFE, A_CNT, A_CMPA, A_CMPB, A_PER};
    foreach (offs[i]) begin
      rd(offs[i], d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset pins", {30'b0, pin_a, pin_b}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_DIR, 32'hFFFF_FFFF);  rd(A_DIR, d);  chk("R2 direction bits 1:0", d, 32'h3);
    wr(A_BUFE, 32'hA5A5_5A5A); rd(A_BUFE, d); chk("R2 buffer enable", d, 32'hA5A5_5A5A);
    wr(A_PINC, 32'hFFFF_FFFF); rd(A_PINC, d); chk("R2 pin control fields", d, 32'h011F_011F);
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, d); chk("R2 control fields", d, 32'h0707_0000);
    wr(A_CMPB, 32'h1234_5678); rd(A_CMPB, d); chk("R2 compare B", d, 32'h1234_5678);
    rd(8'h00, d); chk("R2 unmapped offset", d, 32'h0);
    wr(A_CTRL, 32'h0); wr(A_PINC, 32'h0); wr(A_CMPB, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(A_CTRL, 32'h0000_0001);
    wr(A_CTRL, 32'h0307_0001); rd(A_CTRL, d); chk("R3 mode/prescale locked while running", d, 32'h0000_0001);
    wr(A_CTRL, 32'h0307_0000); rd(A_CTRL, d); chk("R3 stopping write keeps fields", d, 32'h0000_0000);
    wr(A_CTRL, 32'h0307_0000); rd(A_CTRL, d); chk("R3 fields written while stopped", d, 32'h0307_0000);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_saw();
    logic [31:0] d;
    wr(A_PER, 5); wr(A_CMPA, 2); wr(A_CMPB, 4); wr(A_CNT, 0);
    wr(A_PINC, 32'h011B_011B);
    chk("R10 pins low before start", {30'b0, pin_a, pin_b}, 32'h0);
    wr(A_CTRL, 32'h1);
    for (int k = 0; k < 20; k++) begin
      rd(A_CNT, d);
      chk("R4/R5 sawtooth count", d, k % 6);
      chk("R8 pin A level", {31'b0, pin_a}, {31'b0, (k % 6) < 2});
      chk("R8 pin B level", {31'b0, pin_b}, {31'b0, (k % 6) < 4});
      @(negedge clk);
    end
  endtask

  task automatic t_over();
    wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_CMPB, 9); wr(A_CTRL, 1);
    for (int k = 0; k < 14; k++) begin
      chk("R9 compare above period stays high", {31'b0, pin_b}, 32'h1);
      @(negedge clk);
    end
  endtask

  task automatic t_gate();
    logic [31:0] d, c;
    wr(A_PINC, 32'h001B_011B);
    for (int k = 0; k < 8; k++) begin
      rd(A_CNT, d);
      chk("R10 disabled pin B low", {31'b0, pin_b}, 32'h0);
      chk("R8 pin A still toggling", {31'b0, pin_a}, {31'b0, d < 2});
      @(negedge clk);
    end
    wr(A_PINC, 32'h011B_0113);
    for (int k = 0; k < 6; k++) begin
      chk("R10 wrong action code keeps A low", {31'b0, pin_a}, 32'h0);
      @(negedge clk);
    end
    wr(A_PINC, 32'h011B_011B);
    wr(A_CTRL, 0);
    rd(A_CNT, c);
    repeat (5) @(negedge clk);
    rd(A_CNT, d); chk("R4 counter holds while stopped", d, c);
    chk("R10 pins low while stopped", {30'b0, pin_a, pin_b}, 32'h0);
    wr(A_CTRL, 32'h0001_0001);
    repeat (5) @(negedge clk);
    rd(A_CNT, d); chk("R4 counter holds in non-sawtooth mode", d, c);
    chk("R10 pins low in non-sawtooth mode", {30'b0, pin_a, pin_b}, 32'h0);
    wr(A_CTRL, 0); wr(A_CTRL, 0);
  endtask

  task automatic t_cntwr();
    logic [31:0] d;
    wr(A_PER, 10); wr(A_CNT, 0); wr(A_CTRL, 1);
    repeat (3) @(negedge clk);
    rd(A_CNT, d); chk("R4 count after three ticks", d, 3);
    wr(A_CNT, 7); rd(A_CNT, d); chk("R7 counter write wins over tick", d, 7);
    @(negedge clk); rd(A_CNT, d); chk("R7 count resumes after write", d, 8);
    wr(A_CNT, 20); rd(A_CNT, d); chk("R7 write above period", d, 20);
    @(negedge clk); rd(A_CNT, d); chk("R5 wrap from above period", d, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_presc(input logic [2:0] code, input int clocks, input int ticks);
    logic [31:0] d;
    wr(A_PER, 32'hFFFF_FFFF); wr(A_CNT, 0);
    wr(A_CTRL, {5'b0, code, 23'b0, 1'b1});
    repeat (clocks - 1) @(negedge clk);
    rd(A_CNT, d); chk("R6 count one clock before tick", d, ticks - 1);
    @(negedge clk);
    rd(A_CNT, d); chk("R6 count on tick", d, ticks);
    wr(A_CTRL, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_lock();
    t_saw();
    t_over();
    t_gate();
    t_cntwr();
    t_presc(3'd1, 40, 10);
    t_presc(3'd5, 1024, 1);
    t_presc(3'd7, 2048, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule